// File: doc/BRIEF.md
# Speculative Line-Fill Abandon Controller

This block steers the refill of an instruction cache when a single demand miss is followed by a burst of speculatively prefetched lines. It tracks each doubleword beat that arrives from the memory bus, builds the current line in a fill buffer and forwards every beat to the fetch unit straight away. It writes a line into the cache only when all four beats of a line it has kept are present.

When the fetch unit raises a fresh miss in the middle of a burst, the block decides how much of the burst survives. If the demand line is still arriving, that line is always finished and every speculative line is cancelled. If a speculative line is arriving, the lines behind it are cancelled. The line itself is kept or dropped depending on a programmable beat threshold. A dropped line is never written into the cache, and the next line's beats overwrite it in the fill buffer.

The bus side sees a one-cycle cancel pulse and a one-cycle request pulse for each new demand line. Configuration sets how many speculative lines follow a demand line (0 to 3) and the drop threshold (0 to 3).

Top module: `ifill_abandon_ctrl`

## Requirements
- R1: After reset, every output is low and no burst is open.
- R2: A miss while idle raises req_o for exactly one cycle, in the cycle after the miss. The burst that follows holds one demand line and then spec_lines_i speculative lines, with the count sampled when the burst starts. The block returns to idle after the last beat of the last line.
- R3: line_wr_o pulses for one cycle, in the cycle after the fourth beat of a kept line. It never stays high two cycles running. While it is high, line_data_o holds beat k of the line in bits [64k+63:64k], where k counts from 0 in arrival order.
- R4: A miss taken during a burst cancels every speculative line after the line in flight. abandon_o pulses for one cycle after the miss when something is cancelled.
- R5: A miss taken while a speculative line is in flight drops that line when both of these hold: abandon_thr_i is nonzero, and the beats received are fewer than abandon_thr_i. A beat in the same cycle as the miss counts as received. A dropped line is never written.
- R6: A miss taken while the demand line is incomplete never drops that line, whatever the threshold. The line is completed and written, and the new req_o comes in the same cycle as its line_wr_o.
- R7: After a drop, abandon_o is high in the cycle after the miss and req_o is high in the cycle after that. Beats and misses are ignored in the cycle between the two.
- R8: bypass_valid_o pulses in the cycle after each beat accepted during a burst, and bypass_data_o carries that beat. This includes beats of lines that are later dropped. Beats outside a burst are ignored.
- R9: buf_overwrite_o pulses with the bypass of the first beat that arrives after a dropped line that had left at least one beat in the fill buffer.
- R10: A miss that arrives while a new demand line is already pending is ignored.
- R11: With a threshold of 0, a speculative line in flight is always completed. With a threshold of 3, the line is dropped when two or fewer beats have arrived and kept when three have.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_i | input | 1 | Demand miss from the fetch unit |
| spec_lines_i | input | 2 | Number of speculative lines after a demand line |
| abandon_thr_i | input | 2 | Beat threshold for dropping a speculative line |
| beat_valid_i | input | 1 | Doubleword beat present on the bus |
| beat_data_i | input | 64 | Doubleword beat data |
| req_o | output | 1 | Request a new demand line (one cycle) |
| abandon_o | output | 1 | Tell the bus to stop the current burst (one cycle) |
| line_wr_o | output | 1 | Write the fill buffer into the cache (one cycle) |
| line_data_o | output | 256 | Fill buffer contents |
| bypass_valid_o | output | 1 | Forwarded beat valid |
| bypass_data_o | output | 64 | Forwarded beat data |
| buf_overwrite_o | output | 1 | A partial dropped line is being overwritten |

## Verification
A beat counter that drifts by one shows up at once. line_wr_o fires one beat early or late, and line_data_o then has a slot out of place in that same cycle. A wrong count of remaining speculative lines shows up later, at the end of the burst: the block either stays busy past the last line or goes idle before it, and the next miss then gives a req_o or abandon_o where none was due. A lost pending flag or a lost dirty mark is silent until the next miss or the next beat. It then appears as a missing req_o after a kept line, or as a wrong buf_overwrite_o pulse, so the directed cases push a miss or a beat in right after each decision.

// File: rtl/ifill_pkg.sv
package ifill_pkg;
  typedef enum logic [1:0] {
    FS_IDLE   = 2'd0,
    FS_FILL   = 2'd1,
    FS_LAUNCH = 2'd2
  } fill_st_e;
endpackage

// File: rtl/ifill_fill_buf.sv
module ifill_fill_buf #(
  parameter int BEAT_W = 64,
  parameter int BEATS  = 4,
  parameter int IDX_W  = $clog2(BEATS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [BEAT_W-1:0]       data_i,
  output logic [BEAT_W*BEATS-1:0] line_o
);
  for (genvar s = 0; s < BEATS; s++) begin : g_slot
    logic [BEAT_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            slot_q <= '0;
      else if (wr_i && idx_i == IDX_W'(s))    slot_q <= data_i;
    end
    assign line_o[s*BEAT_W +: BEAT_W] = slot_q;
  end
endmodule

// File: rtl/ifill_abandon_dec.sv
module ifill_abandon_dec #(
  parameter int CNT_W  = 2,
  parameter int SPEC_W = 2
) (
  input  logic [CNT_W:0]    rcvd_i,
  input  logic [CNT_W-1:0]  thr_i,
  input  logic              is_demand_i,
  input  logic [SPEC_W-1:0] spec_left_i,
  output logic              drop_o,
  output logic              cancel_o
);
  // demand lines are never dropped; threshold 0 keeps everything
  assign drop_o   = !is_demand_i && (thr_i != '0) && (rcvd_i < {1'b0, thr_i});
  assign cancel_o = drop_o || (spec_left_i != '0);
endmodule

// File: rtl/ifill_ctrl.sv
module ifill_ctrl
  import ifill_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int SPEC_W = 2,
  parameter int CNT_W  = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic              beat_i,
  input  logic [SPEC_W-1:0] spec_cfg_i,
  input  logic [CNT_W-1:0]  thr_cfg_i,
  output logic [CNT_W-1:0]  slot_o,
  output logic              beat_acc_o,
  output logic              req_o,
  output logic              line_wr_o,
  output logic              abandon_o,
  output logic              overwrite_o
);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(BEATS - 1);

  fill_st_e          st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SPEC_W-1:0] spec_q, spec_d;
  logic              dem_q, dem_d, pend_q, pend_d, dirty_q, dirty_d;
  logic              req_d, wr_d, ab_d, ovw_d;
  logic              beat_acc, miss_acc, last_beat, start;
  logic [CNT_W:0]    rcvd;
  logic              drop, cancel;

  assign beat_acc  = (st_q == FS_FILL) && beat_i;
  assign last_beat = beat_acc && (cnt_q == LAST_SLOT);
  assign rcvd      = {1'b0, cnt_q} + (CNT_W+1)'(beat_acc);
  assign miss_acc  = miss_i && ((st_q == FS_IDLE) || (st_q == FS_FILL && !pend_q));

  ifill_abandon_dec #(
    .CNT_W (CNT_W),
    .SPEC_W(SPEC_W)
  ) u_dec (
    .rcvd_i     (rcvd),
    .thr_i      (thr_cfg_i),
    .is_demand_i(dem_q),
    .spec_left_i(spec_q),
    .drop_o     (drop),
    .cancel_o   (cancel)
  );

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    spec_d  = spec_q;
    dem_d   = dem_q;
    pend_d  = pend_q;
    dirty_d = dirty_q;
    req_d   = 1'b0;
    wr_d    = last_beat;
    ab_d    = 1'b0;
    ovw_d   = beat_acc && (cnt_q == '0) && dirty_q;
    start   = 1'b0;
    if (beat_acc) cnt_d = cnt_q + CNT_W'(1);
    if (beat_acc && cnt_q == '0) dirty_d = 1'b0;
    unique case (st_q)
      FS_IDLE:   if (miss_acc) start = 1'b1;
      FS_LAUNCH: start = 1'b1;
      FS_FILL: begin
        if (miss_acc) begin
          ab_d = cancel;
          if (last_beat) begin
            start = 1'b1;
          end else if (drop) begin
            st_d    = FS_LAUNCH;
            cnt_d   = '0;
            dirty_d = dirty_d | (rcvd != '0);
          end else begin
            spec_d = '0;
            pend_d = 1'b1;
          end
        end else if (last_beat) begin
          if (spec_q != '0) begin
            spec_d = spec_q - SPEC_W'(1);
            dem_d  = 1'b0;
          end else if (pend_q) begin
            start = 1'b1;
          end else begin
            st_d = FS_IDLE;
          end
        end
      end
      default: st_d = FS_IDLE;
    endcase
    if (start) begin
      st_d   = FS_FILL;
      req_d  = 1'b1;
      cnt_d  = '0;
      dem_d  = 1'b1;
      spec_d = spec_cfg_i;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= FS_IDLE;
      cnt_q       <= '0;
      spec_q      <= '0;
      dem_q       <= 1'b0;
      pend_q      <= 1'b0;
      dirty_q     <= 1'b0;
      req_o       <= 1'b0;
      line_wr_o   <= 1'b0;
      abandon_o   <= 1'b0;
      overwrite_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      spec_q      <= spec_d;
      dem_q       <= dem_d;
      pend_q      <= pend_d;
      dirty_q     <= dirty_d;
      req_o       <= req_d;
      line_wr_o   <= wr_d;
      abandon_o   <= ab_d;
      overwrite_o <= ovw_d;
    end
  end

  assign slot_o     = cnt_q;
  assign beat_acc_o = beat_acc;

  p_wr_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_wr_o |=> !line_wr_o);
  p_req_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  p_drop_then_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abandon_o && st_q == FS_LAUNCH) |=> (req_o && st_q == FS_FILL));
  p_no_spec_when_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (spec_q == '0));
  p_demand_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FS_FILL && dem_q && miss_acc) |=> (st_q == FS_FILL));
  p_idle_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != FS_FILL) |-> (cnt_q == '0));
endmodule

// File: rtl/ifill_abandon_ctrl.sv
module ifill_abandon_ctrl #(
  parameter int BEAT_W = 64,
  parameter int BEATS  = 4,
  parameter int SPEC_W = 2,
  parameter int CNT_W  = $clog2(BEATS),
  parameter int LINE_W = BEAT_W * BEATS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic [SPEC_W-1:0] spec_lines_i,
  input  logic [CNT_W-1:0]  abandon_thr_i,
  input  logic              beat_valid_i,
  input  logic [BEAT_W-1:0] beat_data_i,
  output logic              req_o,
  output logic              abandon_o,
  output logic              line_wr_o,
  output logic [LINE_W-1:0] line_data_o,
  output logic              bypass_valid_o,
  output logic [BEAT_W-1:0] bypass_data_o,
  output logic              buf_overwrite_o
);
  logic [CNT_W-1:0] slot;
  logic             beat_acc;

  ifill_ctrl #(
    .BEATS (BEATS),
    .SPEC_W(SPEC_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .miss_i     (miss_i),
    .beat_i     (beat_valid_i),
    .spec_cfg_i (spec_lines_i),
    .thr_cfg_i  (abandon_thr_i),
    .slot_o     (slot),
    .beat_acc_o (beat_acc),
    .req_o      (req_o),
    .line_wr_o  (line_wr_o),
    .abandon_o  (abandon_o),
    .overwrite_o(buf_overwrite_o)
  );

  ifill_fill_buf #(
    .BEAT_W(BEAT_W),
    .BEATS (BEATS),
    .IDX_W (CNT_W)
  ) u_buf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (beat_acc),
    .idx_i (slot),
    .data_i(beat_data_i),
    .line_o(line_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bypass_valid_o <= 1'b0;
      bypass_data_o  <= '0;
    end else begin
      bypass_valid_o <= beat_acc;
      if (beat_acc) bypass_data_o <= beat_data_i;
    end
  end

  p_ovw_with_beat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_overwrite_o |-> bypass_valid_o);
  p_wr_with_beat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_wr_o |-> (bypass_valid_o && bypass_data_o == line_data_o[LINE_W-1 -: BEAT_W]));
  p_ab_no_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abandon_o && !req_o && !line_wr_o && !bypass_valid_o) |-> !buf_overwrite_o);
endmodule

// File: tb/ifill_abandon_ctrl_bench.sv
module ifill_abandon_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         miss_i = 1'b0;
  logic [1:0]   spec_i = '0;
  logic [1:0]   thr_i = '0;
  logic         beat_i = 1'b0;
  logic [63:0]  bdata_i = '0;
  logic         req_o, ab_o, wr_o, byp_o, ovw_o;
  logic [255:0] line_o;
  logic [63:0]  bypd_o;

  int n_tests = 0, n_fail = 0;
  int c_req = 0, c_wr = 0, c_ab = 0, c_ovw = 0;
  logic [255:0] last_line = '0;

  // reference model
  int          m_st = 0, m_cnt = 0, m_spec = 0;
  bit          m_dem = 0, m_pend = 0, m_dirty = 0;
  logic [63:0] m_line [4];
  bit          e_req, e_wr, e_ab, e_byp, e_ovw;
  logic [63:0] e_bd;

  always #2 clk = ~clk;

  ifill_abandon_ctrl u_ifill_abandon_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .miss_i(miss_i), .spec_lines_i(spec_i),
    .abandon_thr_i(thr_i), .beat_valid_i(beat_i), .beat_data_i(bdata_i),
    .req_o(req_o), .abandon_o(ab_o), .line_wr_o(wr_o), .line_data_o(line_o),
    .bypass_valid_o(byp_o), .bypass_data_o(bypd_o), .buf_overwrite_o(ovw_o));

  task automatic chk(input string tag, input string what, input logic [255:0] got,
                     input logic [255:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic model(input bit miss, input bit beat, input logic [63:0] d);
    bit acc, start;
    int n;
    e_req = 0; e_wr = 0; e_ab = 0; e_byp = 0; e_ovw = 0; start = 0;
    acc = (m_st == 1) && beat;
    if (acc) begin
      e_byp = 1; e_bd = d; m_line[m_cnt] = d;
      if (m_cnt == 0 && m_dirty) begin e_ovw = 1; m_dirty = 0; end
    end
    n = m_cnt + int'(acc);
    if (m_st == 0) begin
      if (miss) start = 1;
    end else if (m_st == 2) begin
      start = 1;
    end else begin
      if (n == 4) e_wr = 1;
      if (miss && !m_pend) begin
        if (n == 4) begin e_ab = (m_spec > 0); start = 1; end
        else if (!m_dem && thr_i != 0 && n < int'(thr_i)) begin
          e_ab = 1; m_st = 2; m_cnt = 0; if (n > 0) m_dirty = 1;
        end else begin e_ab = (m_spec > 0); m_spec = 0; m_pend = 1; m_cnt = n; end
      end else if (n == 4) begin
        m_cnt = 0;
        if (m_spec > 0) begin m_spec--; m_dem = 0; end
        else if (m_pend) start = 1;
        else m_st = 0;
      end else m_cnt = n;
    end
    if (start) begin
      m_st = 1; e_req = 1; m_cnt = 0; m_dem = 1; m_spec = int'(spec_i); m_pend = 0;
    end
  endtask

  task automatic step(input bit miss, input bit beat, input logic [63:0] d);
    @(negedge clk);
    miss_i = miss; beat_i = beat; bdata_i = d;
    @(posedge clk);
    model(miss, beat, d);
    #1;
    chk("R2", "req_o", 256'(req_o), 256'(e_req));
    chk("R4", "abandon_o", 256'(ab_o), 256'(e_ab));
    chk("R3", "line_wr_o", 256'(wr_o), 256'(e_wr));
    chk("R8", "bypass_valid_o", 256'(byp_o), 256'(e_byp));
    chk("R9", "buf_overwrite_o", 256'(ovw_o), 256'(e_ovw));
    if (e_byp) chk("R8", "bypass_data_o", 256'(bypd_o), 256'(e_bd));
    if (e_wr) chk("R3", "line_data_o", line_o, {m_line[3], m_line[2], m_line[1], m_line[0]});
    c_req += int'(req_o); c_wr += int'(wr_o); c_ab += int'(ab_o); c_ovw += int'(ovw_o);
    if (wr_o) last_line = line_o;
  endtask

  task automatic beats(input int k, input logic [63:0] base);
    for (int i = 0; i < k; i++) step(0, 1, base + 64'(i));
  endtask

  task automatic flush();
    for (int i = 0; i < 200 && m_st != 0; i++) step(0, 1, 64'($urandom));
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int r0, w0, a0;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "req_o", 256'(req_o), 0);
    chk("R1", "abandon_o", 256'(ab_o), 0);
    chk("R1", "line_wr_o", 256'(wr_o), 0);
    chk("R1", "bypass_valid_o", 256'(byp_o), 0);
    chk("R1", "buf_overwrite_o", 256'(ovw_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R3: one demand + one speculative line, full burst
    spec_i = 2'd1; thr_i = 2'd0;
    r0 = c_req; w0 = c_wr; a0 = c_ab;
    step(1, 0, 0);
    beats(4, 64'h100); beats(4, 64'h200);
    chk("R2", "requests", 256'(c_req - r0), 1);
    chk("R3", "line writes", 256'(c_wr - w0), 2);
    chk("R3", "second line data", last_line,
        {64'h203, 64'h202, 64'h201, 64'h200});
    step(0, 1, 64'hdead);  // R8: beat while idle
    chk("R8", "idle beat ignored", 256'(byp_o), 0);

    // R5/R11: threshold 3, two beats in speculative line -> dropped
    spec_i = 2'd3; thr_i = 2'd3;
    r0 = c_req; w0 = c_wr; a0 = c_ab;
    step(1, 0, 0); beats(4, 64'h300); beats(2, 64'h400);
    step(1, 0, 0);
    chk("R7", "abandon after drop", 256'(ab_o), 1);
    step(0, 1, 64'h999);  // ignored in gap (R7)
    chk("R7", "req after abandon", 256'(req_o), 1);
    chk("R7", "gap beat ignored", 256'(byp_o), 0);
    chk("R5", "dropped line not written", 256'(c_wr - w0), 1);
    step(0, 1, 64'h500);
    chk("R9", "overwrite on first new beat", 256'(ovw_o), 1);
    flush();

    // R11 boundary: threshold 3, three beats -> kept
    r0 = c_req; w0 = c_wr; a0 = c_ab;
    step(1, 0, 0); beats(4, 64'h600); beats(3, 64'h700);
    step(1, 0, 0);
    chk("R4", "cut later lines", 256'(c_ab - a0), 1);
    step(0, 1, 64'h703);
    chk("R11", "three beats kept", 256'(c_wr - w0), 2);
    chk("R11", "req with write", 256'(req_o & wr_o), 1);
    flush();

    // R11 threshold 0 keeps, R10 second miss while pending ignored
    spec_i = 2'd2; thr_i = 2'd0;
    r0 = c_req; w0 = c_wr; a0 = c_ab;
    step(1, 0, 0); beats(4, 64'h800); beats(1, 64'h900);
    step(1, 0, 0);
    step(1, 0, 0);
    chk("R10", "pending miss ignored", 256'(c_req - r0), 1);
    beats(3, 64'h901);
    chk("R11", "thr0 line kept", 256'(c_wr - w0), 2);
    chk("R10", "one cancel only", 256'(c_ab - a0), 1);
    flush();

    // R6: miss during incomplete demand line
    spec_i = 2'd3; thr_i = 2'd3;
    r0 = c_req; w0 = c_wr; a0 = c_ab;
    step(1, 0, 0); beats(1, 64'ha00);
    step(1, 0, 0);
    chk("R6", "spec lines cancelled", 256'(ab_o), 1);
    beats(3, 64'ha01);
    chk("R6", "demand line written", 256'(c_wr - w0), 1);
    chk("R6", "new req with write", 256'(req_o & wr_o), 1);
    chk("R6", "demand line data", last_line, {64'ha03, 64'ha02, 64'ha01, 64'ha00});
    flush();

    // R9: drop with zero beats leaves nothing to overwrite
    thr_i = 2'd1; a0 = c_ovw;
    step(1, 0, 0); beats(4, 64'hb00);
    step(1, 0, 0); step(0, 0, 0);
    step(0, 1, 64'hc00);
    chk("R9", "no overwrite after empty drop", 256'(c_ovw - a0), 0);
    flush();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (m_st == 0 && ($urandom % 8) == 0) begin
        spec_i = 2'($urandom); thr_i = 2'($urandom);
      end
      step(($urandom % 16) == 0, ($urandom % 10) < 6, {$urandom, $urandom});
    end
    flush();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule